// File: doc/BRIEF.md
# SPI NOR Flash Operation Sequencer

This block sits between a host and a serial NOR flash. It turns one host request into the sequence of chip-select framed SPI commands that the flash needs to carry the request out. A request carries an operation (read, page program, 4 KiB sector erase, 64 KiB block erase or whole-device erase), a 24-bit device address and a byte count. The block generates the serial clock, the chip select and the data-out line itself, using a byte-wide shifter.

Every operation first reads the device status until the write-in-progress flag is clear. Modifying operations then send a write-enable frame, then the command itself, and then poll status again until the device has finished. Read data leaves the block on a valid/ready byte stream, and program data enters on a second one. An erase whose address is outside the device or not aligned is refused before any frame goes out. Polling that stays busy too long ends the operation with a timeout code. When the host sees the completion pulse, it also sees a signed 16-bit status code.

Top module: `flash_op_seq`

## Requirements
- R1: After reset the chip select is high, the serial clock is low, the request port is ready, and neither the read stream nor the completion pulse is active.
- R2: The serial link runs in mode 0. The clock idles low, the flash samples on the rising edge and bytes go most significant bit first. One clock period is CLK_DIV system cycles, and the clock stays low whenever chip select is high.
- R3: Every accepted operation starts with status frames. Each frame is opcode 0x05 followed by one status byte, and the frames repeat while bit 0 of that byte is 1.
- R4: A one-byte frame carrying 0x06 is sent directly before each program or erase command frame.
- R5: Host operation codes are 0 read, 1 page program, 2 sector erase, 3 block erase and 4 device erase. They map to flash opcodes 0x03, 0x02, 0x20, 0xD8 and 0x60. Read, program and both erases send three address bytes, most significant first, after the opcode. Read and program data continue in the same frame. Device erase is a single byte.
- R6: After a program or erase frame, status frames repeat until the device is idle. The operation then completes with status 0. A read completes with status 0 once its frame ends.
- R7: A sector erase (or block erase) is refused with status -1 and no chip-select activity in two cases: the address is not a multiple of 4 KiB (64 KiB), or the address plus 4 KiB (64 KiB) is at least DEV_SIZE (default 512 KiB).
- R8: Operation codes 5, 6 and 7 complete with status -1 in the cycle after acceptance, with no chip-select activity.
- R9: If the status read still shows busy once TIMEOUT_CYCLES cycles have passed since the start of the current polling phase, the operation ends with status -2.
- R10: A read whose initial polling times out still delivers exactly the requested number of bytes on the read stream, all 0x00, before completing with status -2.
- R11: Chip select stays high for at least CLK_DIV system cycles between two frames.
- R12: Read bytes leave in address order and one program byte is taken per accepted write-stream handshake. Completion is a one-cycle pulse that is never active at the same time as read-stream valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Sequencer idle, request accepted on this cycle |
| reqOp | input | 3 | Operation code (0 read, 1 program, 2 sector erase, 3 block erase, 4 device erase) |
| reqAddr | input | 24 | Flash byte address |
| reqLen | input | LEN_W | Number of data bytes for read or program |
| wrData | input | 8 | Program data byte |
| wrValid | input | 1 | Program byte present |
| wrReady | output | 1 | Sequencer takes the program byte |
| rdData | output | 8 | Read data byte |
| rdValid | output | 1 | Read byte present |
| rdReady | input | 1 | Host takes the read byte |
| doneValid | output | 1 | One-cycle completion pulse |
| doneStatus | output | 16 | Signed completion code: 0 ok, -1 error, -2 timeout |
| spiSclk | output | 1 | Serial clock |
| spiCsN | output | 1 | Active-low chip select |
| spiMosi | output | 1 | Serial data to flash |
| spiMiso | input | 1 | Serial data from flash |

## Verification
A corrupted phase or byte index would show up on the serial pins within one frame. The flash would see the wrong opcode, a misplaced address byte or a frame with the wrong length. A bench flash model that decodes each frame catches this when the chip select rises. A stuck polling loop or a broken timeout counter shows up as a missing completion pulse, or as a timeout code after roughly TIMEOUT_CYCLES cycles instead of after the programmed number of busy reads. A faulty read path shows up as data that does not match the model's memory in the first delivered byte. On the failure path it shows up as a byte count that differs from the requested length.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  // host operation codes
  localparam logic [2:0] OP_READ = 3'd0;
  localparam logic [2:0] OP_PROG = 3'd1;
  localparam logic [2:0] OP_SECT = 3'd2;
  localparam logic [2:0] OP_BLK  = 3'd3;
  localparam logic [2:0] OP_CHIP = 3'd4;

  // flash command bytes
  localparam logic [7:0] FC_STATUS = 8'h05;
  localparam logic [7:0] FC_WREN   = 8'h06;
  localparam logic [7:0] FC_READ   = 8'h03;
  localparam logic [7:0] FC_PROG   = 8'h02;
  localparam logic [7:0] FC_SECT   = 8'h20;
  localparam logic [7:0] FC_BLK    = 8'hD8;
  localparam logic [7:0] FC_CHIP   = 8'h60;

  localparam logic [15:0] ST_OK  = 16'h0000;
  localparam logic [15:0] ST_ERR = 16'hFFFF;
  localparam logic [15:0] ST_TMO = 16'hFFFE;

  // strobes from control to the serial datapath
  typedef struct packed {
    logic       load;
    logic       csSet;
    logic       csClr;
    logic [7:0] txByte;
  } dpCmd_t;
endpackage

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCmd_t     cmd,
  output logic       idle,
  output logic       byteDone,
  output logic [7:0] rxByte,
  output logic       spiSclk,
  output logic       spiCsN,
  output logic       spiMosi,
  input  logic       spiMiso
);
  localparam int HALF = CLK_DIV / 2;
  localparam int DW   = $clog2(HALF + 1);
  localparam int GW   = $clog2(CLK_DIV + 1);

  logic [DW-1:0] divCnt;
  logic [GW-1:0] gapCnt;
  logic [2:0]    bitCnt;
  logic [7:0]    shReg;
  logic          busy;

  assign idle    = !busy && (gapCnt == '0);
  assign spiMosi = shReg[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      gapCnt   <= '0;
      bitCnt   <= '0;
      shReg    <= '0;
      rxByte   <= '0;
      busy     <= 1'b0;
      byteDone <= 1'b0;
      spiSclk  <= 1'b0;
      spiCsN   <= 1'b1;
    end else begin
      byteDone <= 1'b0;
      if (gapCnt != '0) gapCnt <= gapCnt - 1'b1;
      if (cmd.csClr) begin
        spiCsN <= 1'b1;
        gapCnt <= GW'(CLK_DIV);
      end
      if (cmd.load) begin
        shReg  <= cmd.txByte;
        busy   <= 1'b1;
        bitCnt <= '0;
        divCnt <= '0;
        if (cmd.csSet) spiCsN <= 1'b0;
      end else if (busy) begin
        if (divCnt == DW'(HALF - 1)) begin
          divCnt <= '0;
          if (!spiSclk) begin
            spiSclk <= 1'b1;
            rxByte  <= {rxByte[6:0], spiMiso};
          end else begin
            spiSclk <= 1'b0;
            shReg   <= {shReg[6:0], 1'b0};
            bitCnt  <= bitCnt + 1'b1;
            if (bitCnt == 3'd7) begin
              busy     <= 1'b0;
              byteDone <= 1'b1;
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  // cycles chip select has been high, for the gap check
  logic [GW:0] csHighCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csHighCnt <= (GW+1)'(CLK_DIV);
    else if (!spiCsN) csHighCnt <= '0;
    else if (csHighCnt != '1) csHighCnt <= csHighCnt + 1'b1;
  end

  // R2
  sclk_low_when_deselected_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSclk);
  // R11
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiCsN) |-> csHighCnt >= (GW+1)'(CLK_DIV));
  // R2
  load_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |-> idle);
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int LEN_W          = 16,
  parameter int DEV_SIZE       = 524288,
  parameter int SECT_SIZE      = 4096,
  parameter int BLK_SIZE       = 65536,
  parameter int TIMEOUT_CYCLES = 125000000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [2:0]       reqOp,
  input  logic [23:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [7:0]       wrData,
  input  logic             wrValid,
  output logic             wrReady,
  output logic [7:0]       rdData,
  output logic             rdValid,
  input  logic             rdReady,
  output logic             doneValid,
  output logic [15:0]      doneStatus,
  output dpCmd_t           cmd,
  input  logic             dpIdle,
  input  logic             dpByteDone,
  input  logic [7:0]       dpRx
);
  localparam int IW = LEN_W + 3;
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  typedef enum logic [1:0] {PH_PRE, PH_WREN, PH_MAIN, PH_POST} phase_e;
  typedef enum logic [2:0] {S_IDLE, S_SEND, S_WAIT, S_RDOUT, S_ENDF, S_ZERO, S_DONE} state_e;

  state_e           state;
  phase_e           phase;
  logic [2:0]       op;
  logic [23:0]      addr;
  logic [LEN_W-1:0] len;
  logic [IW-1:0]    idx;
  logic [15:0]      status;
  logic [TW-1:0]    tmr;

  logic          isPoll, needWr, lastByte, rangeBad;
  logic [IW-1:0] frameLen;
  logic [7:0]    txSel, mainCode;
  logic [31:0]   reqAddr32;

  assign reqAddr32 = {8'd0, reqAddr};
  always_comb begin
    rangeBad = 1'b0;
    if (reqOp == OP_SECT)
      rangeBad = ((reqAddr32 & 32'(SECT_SIZE - 1)) != 0) || (reqAddr32 + 32'(SECT_SIZE) >= 32'(DEV_SIZE));
    else if (reqOp == OP_BLK)
      rangeBad = ((reqAddr32 & 32'(BLK_SIZE - 1)) != 0) || (reqAddr32 + 32'(BLK_SIZE) >= 32'(DEV_SIZE));
  end

  always_comb begin
    case (op)
      OP_READ: mainCode = FC_READ;
      OP_PROG: mainCode = FC_PROG;
      OP_SECT: mainCode = FC_SECT;
      OP_BLK:  mainCode = FC_BLK;
      default: mainCode = FC_CHIP;
    endcase
    isPoll = (phase == PH_PRE) || (phase == PH_POST);
    if (isPoll) frameLen = IW'(2);
    else if (phase == PH_WREN || op == OP_CHIP) frameLen = IW'(1);
    else if (op == OP_SECT || op == OP_BLK) frameLen = IW'(4);
    else frameLen = IW'(4) + IW'(len);
    lastByte = (idx == frameLen - 1'b1);
    needWr   = (phase == PH_MAIN) && (op == OP_PROG) && (idx >= IW'(4));
    if (isPoll) txSel = (idx == '0) ? FC_STATUS : 8'h00;
    else if (phase == PH_WREN) txSel = FC_WREN;
    else if (idx == '0) txSel = mainCode;
    else if (idx == IW'(1)) txSel = addr[23:16];
    else if (idx == IW'(2)) txSel = addr[15:8];
    else if (idx == IW'(3)) txSel = addr[7:0];
    else txSel = needWr ? wrData : 8'h00;
  end

  assign reqReady    = (state == S_IDLE);
  assign wrReady     = (state == S_SEND) && needWr && dpIdle;
  assign rdValid     = (state == S_RDOUT) || (state == S_ZERO);
  assign rdData      = (state == S_ZERO) ? 8'h00 : dpRx;
  assign doneValid   = (state == S_DONE);
  assign doneStatus  = status;
  assign cmd.load    = (state == S_SEND) && dpIdle && (!needWr || wrValid);
  assign cmd.csSet   = (idx == '0);
  assign cmd.csClr   = (state == S_ENDF);
  assign cmd.txByte  = txSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      phase  <= PH_PRE;
      op     <= '0;
      addr   <= '0;
      len    <= '0;
      idx    <= '0;
      status <= ST_OK;
      tmr    <= '0;
    end else begin
      if (tmr != TW'(TIMEOUT_CYCLES)) tmr <= tmr + 1'b1;
      case (state)
        S_IDLE: if (reqValid) begin
          op    <= reqOp;
          addr  <= reqAddr;
          len   <= reqLen;
          idx   <= '0;
          tmr   <= '0;
          phase <= PH_PRE;
          if (reqOp > OP_CHIP || rangeBad) begin
            status <= ST_ERR;
            state  <= S_DONE;
          end else begin
            state <= S_SEND;
          end
        end
        S_SEND: if (cmd.load) state <= S_WAIT;
        S_WAIT: if (dpByteDone) begin
          if (phase == PH_MAIN && op == OP_READ && idx >= IW'(4)) state <= S_RDOUT;
          else if (lastByte) state <= S_ENDF;
          else begin
            idx   <= idx + 1'b1;
            state <= S_SEND;
          end
        end
        S_RDOUT: if (rdReady) begin
          if (lastByte) state <= S_ENDF;
          else begin
            idx   <= idx + 1'b1;
            state <= S_SEND;
          end
        end
        S_ENDF: begin
          idx   <= '0;
          state <= S_SEND;
          if (isPoll) begin
            if (dpRx[0]) begin
              if (tmr >= TW'(TIMEOUT_CYCLES)) begin
                status <= ST_TMO;
                state  <= (op == OP_READ && len != '0) ? S_ZERO : S_DONE;
              end
            end else if (phase == PH_PRE) begin
              phase <= (op == OP_READ) ? PH_MAIN : PH_WREN;
            end else begin
              status <= ST_OK;
              state  <= S_DONE;
            end
          end else if (phase == PH_WREN) begin
            phase <= PH_MAIN;
          end else if (op == OP_READ) begin
            status <= ST_OK;
            state  <= S_DONE;
          end else begin
            phase <= PH_POST;
            tmr   <= '0;
          end
        end
        S_ZERO: if (rdReady) begin
          len <= len - 1'b1;
          if (len == LEN_W'(1)) state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8
  bad_op_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqOp > OP_CHIP) |=> (doneValid && doneStatus == ST_ERR));
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  // R12
  rd_done_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdValid && doneValid));
  // R5
  wr_only_in_program_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> (op == OP_PROG && phase == PH_MAIN));
endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import flash_seq_pkg::*;
#(
  parameter int CLK_DIV        = 8,
  parameter int LEN_W          = 16,
  parameter int DEV_SIZE       = 524288,
  parameter int SECT_SIZE      = 4096,
  parameter int BLK_SIZE       = 65536,
  parameter int TIMEOUT_CYCLES = 125000000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [2:0]       reqOp,
  input  logic [23:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [7:0]       wrData,
  input  logic             wrValid,
  output logic             wrReady,
  output logic [7:0]       rdData,
  output logic             rdValid,
  input  logic             rdReady,
  output logic             doneValid,
  output logic [15:0]      doneStatus,
  output logic             spiSclk,
  output logic             spiCsN,
  output logic             spiMosi,
  input  logic             spiMiso
);
  dpCmd_t     cmd;
  logic       dpIdle, dpByteDone;
  logic [7:0] dpRx;

  flash_seq_ctrl #(
    .LEN_W(LEN_W), .DEV_SIZE(DEV_SIZE), .SECT_SIZE(SECT_SIZE),
    .BLK_SIZE(BLK_SIZE), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp), .reqAddr(reqAddr), .reqLen(reqLen),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady),
    .doneValid(doneValid), .doneStatus(doneStatus),
    .cmd(cmd), .dpIdle(dpIdle), .dpByteDone(dpByteDone), .dpRx(dpRx)
  );

  flash_seq_dp #(.CLK_DIV(CLK_DIV)) dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .idle(dpIdle), .byteDone(dpByteDone), .rxByte(dpRx),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );
endmodule

// File: tb/flash_op_seq_test.sv
module flash_op_seq_test;
  localparam int CLK_DIV = 4;
  localparam int TMO     = 3000;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [2:0] reqOp = '0;
  logic [23:0] reqAddr = '0;
  logic [15:0] reqLen = '0;
  logic [7:0] wrData = '0, rdData;
  logic wrValid = 1'b0, wrReady, rdValid, rdReady = 1'b0;
  logic doneValid;
  logic [15:0] doneStatus;
  logic spiSclk, spiCsN, spiMosi, spiMiso;

  int total = 0, bad = 0;
  longint cyc = 0;

  always #4 clk = ~clk;  // 8 ns period, 125 MHz
  always @(posedge clk) cyc++;

  flash_op_seq #(.CLK_DIV(CLK_DIV), .TIMEOUT_CYCLES(TMO)) uut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp), .reqAddr(reqAddr), .reqLen(reqLen),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady),
    .doneValid(doneValid), .doneStatus(doneStatus),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  // ---------------- flash model ----------------
  logic [7:0] mem [256];
  int busyLeft = 0, busyCfg = 0, frames = 0, postPolls = 0, wrenViol = 0, modBytes = 0;
  int mBit = 0, mIdx = 0;
  bit wel = 0;
  logic [7:0] mOp = '0, lastModOp = '0, mIn = '0, mShift = '0, mNext = '0;
  logic [23:0] mAddr = '0, lastModAddr = '0;
  longint lastRise = 0, csRiseCyc = 0;
  int minPer = 1000, maxPer = 0, minGap = 1000;

  assign spiMiso = mShift[7];

  task automatic modelByte(input logic [7:0] b);
    if (mIdx == 0) begin
      mOp = b;
      if (b == 8'h06) wel = 1;
      if (b == 8'h05) begin
        mNext = {7'd0, busyLeft > 0};
        if (busyLeft > 0) busyLeft--;
      end
    end else if (mOp == 8'h03 || mOp == 8'h02 || mOp == 8'h20 || mOp == 8'hD8) begin
      if (mIdx <= 3) mAddr = {mAddr[15:0], b};
      if (mOp == 8'h02 && mIdx >= 4) mem[8'(mAddr + 24'(mIdx - 4))] = b;
      if (mOp == 8'h03 && mIdx >= 3) mNext = mem[8'(mAddr + 24'(mIdx - 3))];
    end
  endtask

  always @(negedge spiCsN) begin
    mBit = 0; mIdx = 0; mShift = 8'h00;
    if (frames > 0 && int'(cyc - csRiseCyc) < minGap) minGap = int'(cyc - csRiseCyc);
  end
  always @(posedge spiSclk) if (!spiCsN) begin
    if (mBit != 0) begin
      if (int'(cyc - lastRise) < minPer) minPer = int'(cyc - lastRise);
      if (int'(cyc - lastRise) > maxPer) maxPer = int'(cyc - lastRise);
    end
    lastRise = cyc;
    mIn = {mIn[6:0], spiMosi};
    mBit++;
    if (mBit == 8) begin
      mBit = 0;
      modelByte(mIn);
      mIdx++;
    end
  end
  always @(negedge spiSclk) if (!spiCsN) begin
    if (mBit == 0) mShift = mNext;
    else mShift = {mShift[6:0], 1'b0};
  end
  always @(posedge spiCsN) if (rstN) begin
    frames++;
    csRiseCyc = cyc;
    if (mOp == 8'h05) postPolls++;
    if (mOp == 8'h02 || mOp == 8'h20 || mOp == 8'hD8 || mOp == 8'h60) begin
      if (!wel) wrenViol++;
      wel = 0;
      busyLeft = busyCfg;
      postPolls = 0;
      lastModOp = mOp;
      lastModAddr = mAddr;
      modBytes = mIdx;
      if (mOp != 8'h02) for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    end
  end

  // ---------------- host streams ----------------
  logic [7:0] wrBuf [64];
  logic [7:0] rdBuf [64];
  int wrCnt = 0, rdCnt = 0, gotStatus = 0;
  bit doneSeen = 0;

  always @(negedge clk) begin
    rdReady = ($urandom % 4) != 0;
    if (rdValid && rdReady) begin
      if (rdCnt < 64) rdBuf[rdCnt] = rdData;
      rdCnt++;
    end
    wrValid = ($urandom % 4) != 0;
    wrData = wrBuf[wrCnt % 64];
    if (wrValid && wrReady) wrCnt++;
    if (doneValid) begin
      doneSeen = 1;
      gotStatus = int'($signed(doneStatus));
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [2:0] op, input logic [23:0] a, input int n);
    rdCnt = 0; wrCnt = 0; doneSeen = 0;
    reqOp = op; reqAddr = a; reqLen = 16'(n); reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!doneSeen) @(negedge clk);
  endtask

  function automatic int expStatus(input logic [2:0] op, input logic [23:0] a);
    int ia = int'(a);
    if (op > 3'd4) return -1;
    if (op == 3'd2) return ((ia % 4096) != 0 || ia + 4096 >= 524288) ? -1 : 0;
    if (op == 3'd3) return ((ia % 65536) != 0 || ia + 65536 >= 524288) ? -1 : 0;
    return 0;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int f0;
    logic [23:0] a;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 64; i++) wrBuf[i] = 8'(8'hA0 + i);
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1", "csN", spiCsN, 1);
    chk("R1", "sclk", spiSclk, 0);
    chk("R1", "reqReady", reqReady, 1);
    chk("R1", "doneValid", doneValid, 0);
    chk("R1", "rdValid", rdValid, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R3 R5 R12: read after two busy status reads
    busyLeft = 2; f0 = frames;
    runOp(3'd0, 24'h000010, 5);
    chk("R6", "read status", gotStatus, 0);
    chk("R3", "read frames (3 polls + read)", frames - f0, 4);
    chk("R12", "read count", rdCnt, 5);
    for (int i = 0; i < 5; i++) chk("R5", "read data", rdBuf[i], mem[8'(8'h10 + i)]);
    chk("R5", "read address", mAddr, 24'h000010);

    // R4 R5 R6: page program with busy after command
    busyCfg = 3; f0 = frames;
    for (int i = 0; i < 8; i++) wrBuf[i] = 8'(8'h5A ^ (i * 17));
    runOp(3'd1, 24'h0001F0, 8);
    chk("R6", "program status", gotStatus, 0);
    chk("R12", "program bytes taken", wrCnt, 8);
    chk("R5", "program opcode", lastModOp, 8'h02);
    chk("R5", "program address", lastModAddr, 24'h0001F0);
    chk("R5", "program frame bytes", modBytes, 12);
    chk("R6", "post polls", postPolls, 4);
    chk("R4", "write enable before program", wrenViol, 0);
    chk("R4", "program frames (poll,wren,cmd,4 polls)", frames - f0, 7);
    for (int i = 0; i < 8; i++) chk("R5", "programmed byte", mem[8'(8'hF0 + i)], wrBuf[i]);
    busyCfg = 0;
    runOp(3'd0, 24'h0001F0, 8);
    for (int i = 0; i < 8; i++) chk("R12", "read back", rdBuf[i], wrBuf[i]);

    // R5 R6 sector, block and device erase
    busyCfg = 1;
    runOp(3'd2, 24'h07E000, 0);
    chk("R6", "sector status", gotStatus, 0);
    chk("R5", "sector opcode", lastModOp, 8'h20);
    chk("R5", "sector address", lastModAddr, 24'h07E000);
    chk("R5", "sector frame bytes", modBytes, 4);
    chk("R6", "sector post polls", postPolls, 2);
    runOp(3'd3, 24'h060000, 0);
    chk("R6", "block status", gotStatus, 0);
    chk("R5", "block opcode", lastModOp, 8'hD8);
    runOp(3'd4, 24'h123456, 0);
    chk("R6", "chip status", gotStatus, 0);
    chk("R5", "chip opcode", lastModOp, 8'h60);
    chk("R5", "chip frame bytes", modBytes, 1);
    chk("R4", "write enable before erases", wrenViol, 0);
    busyCfg = 0;

    // R7 R8 rejected requests
    f0 = frames;
    runOp(3'd2, 24'h000800, 0);
    chk("R7", "misaligned sector", gotStatus, -1);
    runOp(3'd2, 24'h07F000, 0);
    chk("R7", "last sector edge", gotStatus, -1);
    runOp(3'd3, 24'h070000, 0);
    chk("R7", "last block edge", gotStatus, -1);
    runOp(3'd3, 24'h008000, 0);
    chk("R7", "misaligned block", gotStatus, -1);
    runOp(3'd5, 24'h000000, 4);
    chk("R8", "op 5", gotStatus, -1);
    runOp(3'd7, 24'h000000, 0);
    chk("R8", "op 7", gotStatus, -1);
    chk("R7", "no frames for rejects", frames - f0, 0);

    // R9 timeout during pre-poll of erase
    busyLeft = 1000000;
    runOp(3'd2, 24'h001000, 0);
    chk("R9", "erase timeout", gotStatus, -2);
    // R10 read timeout gives zeros
    runOp(3'd0, 24'h000020, 6);
    chk("R9", "read timeout", gotStatus, -2);
    chk("R10", "zero count", rdCnt, 6);
    for (int i = 0; i < 6; i++) chk("R10", "zero byte", rdBuf[i], 0);
    busyLeft = 0;

    // random mix
    for (int it = 0; it < 24; it++) begin
      logic [2:0] op;
      int n;
      op = 3'($urandom % 6);
      busyCfg = int'($urandom % 3);
      n = 1 + int'($urandom % 12);
      case ($urandom % 3)
        0: a = 24'($urandom);
        1: a = 24'(($urandom % 128) * 4096);
        default: a = 24'(($urandom % 8) * 65536);
      endcase
      if (op == 3'd1) begin
        for (int i = 0; i < n; i++) wrBuf[i] = 8'($urandom);
        runOp(op, a, n);
        chk("R6", "random program status", gotStatus, 0);
        runOp(3'd0, a, n);
        for (int i = 0; i < n; i++) chk("R12", "random read back", rdBuf[i], wrBuf[i]);
      end else if (op == 3'd0) begin
        runOp(op, a, n);
        chk("R12", "random read count", rdCnt, n);
        for (int i = 0; i < n; i++) chk("R5", "random read data", rdBuf[i], mem[8'(a + 24'(i))]);
      end else begin
        runOp(op, a, 0);
        chk("R7", "random status", gotStatus, expStatus(op, a));
      end
    end
    chk("R4", "write enable overall", wrenViol, 0);

    // R2 and R11 link timing
    chk("R2", "min sclk period", minPer, CLK_DIV);
    chk("R2", "max sclk period", maxPer, CLK_DIV);
    chk("R11", "cs gap at least CLK_DIV", minGap >= CLK_DIV, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule